// File: doc/BRIEF.md
# Conversion Result Window Compare Event Unit

This unit sits beside an analog-to-digital converter and inspects every finished conversion. Each result carries a 12-bit value and a 4-bit channel number. The value is compared against a programmed window built from a low and a high threshold. One of four conditions can be chosen: below the window, above the window, inside the window, or outside the window.

The unit can watch a single selected channel or every channel. A small filter can require several matching results in a row before an event counts. A qualified event sets a sticky flag, and software clears that flag by reading status. The flag drives the interrupt line only while its enable bit is set. Separate set and clear strobes write the enable bit, and its current value is visible on a port.

Top module: `adc_window_watch`

## Requirements
- R1: Mode code 0 matches a result strictly less than the low threshold.
- R2: Mode code 1 matches a result strictly greater than the high threshold.
- R3: Mode code 2 matches a result with low <= result <= high, so both thresholds are included.
- R4: Mode code 3 matches a result strictly below the low threshold or strictly above the high threshold.
- R5: The window word holds the low threshold in bits 11:0 and the high threshold in bits 27:16. All other bits are ignored.
- R6: With `cfg_watch_all` = 0, only results whose channel equals `cfg_chan_sel` are watched. Results on other channels neither raise an event nor change the match count. With `cfg_watch_all` = 1, every channel is watched.
- R7: A filter value N requires N+1 consecutive matching watched results for one event. A non-matching watched result resets the count to zero, and the count also restarts at zero after each event.
- R8: An event sets `evt_flag` on the next clock. The flag stays set until a cycle with `stat_rd` high, and it reads 0 after that cycle.
- R9: When an event and `stat_rd` occur in the same cycle, `evt_flag` stays set.
- R10: A pulse on `ien_set` sets `ien_mask`, and a pulse on `ien_clr` clears it. If both are high in the same cycle, the clear wins.
- R11: `irq` is high exactly when `evt_flag` and `ien_mask` are both high.
- R12: After reset, `evt_flag`, `ien_mask` and `irq` are 0 and the match count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | A conversion result is present this cycle |
| res_data | input | 12 | Conversion value |
| res_chan | input | 4 | Channel number of the result |
| cfg_mode | input | 2 | Compare condition: 0 below, 1 above, 2 inside, 3 outside |
| cfg_window | input | 32 | Low threshold in bits 11:0, high threshold in bits 27:16 |
| cfg_chan_sel | input | 4 | Channel watched when not watching all |
| cfg_watch_all | input | 1 | Watch every channel |
| cfg_filter | input | 2 | Consecutive match count minus one |
| stat_rd | input | 1 | Status read strobe, clears the flag |
| ien_set | input | 1 | Set the interrupt enable |
| ien_clr | input | 1 | Clear the interrupt enable |
| evt_flag | output | 1 | Sticky comparison event flag |
| ien_mask | output | 1 | Current interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
A table of results is applied in every mode at a fixed window of 100 to 200. The table places values one below, exactly on, and one above each threshold, plus a mid-window value. Together these separate strict from inclusive comparisons, and they would expose swapped low and high fields. Directed sequences then interleave watched and unwatched channels, break a run of matches partway through, and present a read in the same cycle as an event. These show whether the channel gate, the count reset and the set-over-clear priority behave as required. The enable is toggled with the flag both set and clear, including simultaneous set and clear strobes, to separate masking from flag state.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;
  localparam int DATA_W = 12;

  typedef enum logic [1:0] {
    CMP_BELOW   = 2'd0,
    CMP_ABOVE   = 2'd1,
    CMP_INSIDE  = 2'd2,
    CMP_OUTSIDE = 2'd3
  } cmp_mode_e;

  // Condition test of one result against the window.
  function automatic logic window_hit(input cmp_mode_e mode,
                                      input logic [DATA_W-1:0] val,
                                      input logic [DATA_W-1:0] lo,
                                      input logic [DATA_W-1:0] hi);
    logic below, above;
    below = (val < lo);
    above = (val > hi);
    case (mode)
      CMP_BELOW:  return below;
      CMP_ABOVE:  return above;
      CMP_INSIDE: return !below && !above;
      default:    return below || above;
    endcase
  endfunction
endpackage

// File: rtl/wcmp_match.sv
module wcmp_match
  import wcmp_pkg::*;
#(
  parameter int DW     = 12,
  parameter int CHW    = 4,
  parameter int WIN_W  = 32,
  parameter int HI_LSB = 16
) (
  input  logic [DW-1:0]    val,
  input  logic [CHW-1:0]   chan,
  input  logic             valid,
  input  logic [1:0]       mode,
  input  logic [WIN_W-1:0] window,
  input  logic [CHW-1:0]   chan_sel,
  input  logic             watch_all,
  output logic             watched,
  output logic             hit
);
  localparam int HI_MSB = HI_LSB + DW - 1;

  logic [DW-1:0] lo_th, hi_th;

  assign lo_th   = window[DW-1:0];
  assign hi_th   = window[HI_MSB:HI_LSB];
  assign watched = valid && (watch_all || (chan == chan_sel));
  assign hit     = window_hit(cmp_mode_e'(mode), val, lo_th, hi_th);
endmodule

// File: rtl/wcmp_filter.sv
module wcmp_filter #(
  parameter int FW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          watched,
  input  logic          hit,
  input  logic [FW-1:0] need_m1,
  output logic          event_o
);
  logic [FW-1:0] run_cnt;

  assign event_o = watched && hit && (run_cnt >= need_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (watched) begin
      if (!hit || event_o) run_cnt <= '0;
      else                 run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wcmp_flag.sv
module wcmp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic event_i,
  input  logic rd,
  input  logic en_set,
  input  logic en_clr,
  output logic flag,
  output logic en,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      en   <= 1'b0;
    end else begin
      if (event_i)  flag <= 1'b1;
      else if (rd)  flag <= 1'b0;
      if (en_clr)      en <= 1'b0;
      else if (en_set) en <= 1'b1;
    end
  end

  assign irq = flag && en;
endmodule

// File: rtl/adc_window_watch.sv
module adc_window_watch #(
  parameter int DW     = 12,
  parameter int CHW    = 4,
  parameter int FW     = 2,
  parameter int WIN_W  = 32,
  parameter int HI_LSB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  logic [DW-1:0]    res_data,
  input  logic [CHW-1:0]   res_chan,
  input  logic [1:0]       cfg_mode,
  input  logic [WIN_W-1:0] cfg_window,
  input  logic [CHW-1:0]   cfg_chan_sel,
  input  logic             cfg_watch_all,
  input  logic [FW-1:0]    cfg_filter,
  input  logic             stat_rd,
  input  logic             ien_set,
  input  logic             ien_clr,
  output logic             evt_flag,
  output logic             ien_mask,
  output logic             irq
);
  // Named internal events, brought out for the checker.
  logic res_watched;
  logic res_hit;
  logic cmp_event;

  wcmp_match #(.DW(DW), .CHW(CHW), .WIN_W(WIN_W), .HI_LSB(HI_LSB)) u_match (
    .val      (res_data),
    .chan     (res_chan),
    .valid    (res_valid),
    .mode     (cfg_mode),
    .window   (cfg_window),
    .chan_sel (cfg_chan_sel),
    .watch_all(cfg_watch_all),
    .watched  (res_watched),
    .hit      (res_hit)
  );

  wcmp_filter #(.FW(FW)) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .watched(res_watched),
    .hit    (res_hit),
    .need_m1(cfg_filter),
    .event_o(cmp_event)
  );

  wcmp_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .event_i(cmp_event),
    .rd     (stat_rd),
    .en_set (ien_set),
    .en_clr (ien_clr),
    .flag   (evt_flag),
    .en     (ien_mask),
    .irq    (irq)
  );
endmodule

// File: rtl/adc_window_watch_chk.sv
module adc_window_watch_chk #(
  parameter int CHW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           res_valid,
  input logic [CHW-1:0] res_chan,
  input logic [CHW-1:0] cfg_chan_sel,
  input logic           cfg_watch_all,
  input logic           stat_rd,
  input logic           ien_set,
  input logic           ien_clr,
  input logic           cmp_event,
  input logic           evt_flag,
  input logic           ien_mask,
  input logic           irq
);
  a_r6_unwatched_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !cfg_watch_all && (res_chan != cfg_chan_sel)) |-> !cmp_event);

  a_r7_event_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_event |-> res_valid);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !stat_rd) |=> evt_flag);

  a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cmp_event) |=> !evt_flag);

  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_event |=> evt_flag);

  a_r10_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_set && !ien_clr) |=> ien_mask);

  a_r10_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ien_clr |=> !ien_mask);

  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (evt_flag && ien_mask));
endmodule

bind adc_window_watch adc_window_watch_chk #(.CHW(CHW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .res_valid    (res_valid),
  .res_chan     (res_chan),
  .cfg_chan_sel (cfg_chan_sel),
  .cfg_watch_all(cfg_watch_all),
  .stat_rd      (stat_rd),
  .ien_set      (ien_set),
  .ien_clr      (ien_clr),
  .cmp_event    (cmp_event),
  .evt_flag     (evt_flag),
  .ien_mask     (ien_mask),
  .irq          (irq)
);

// File: tb/test_adc_window_watch.sv
module test_adc_window_watch;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;
  // Entry: {expected flag, mode[1:0], value[11:0]}; window is low 100, high 200.
  localparam logic [14:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 12'd99},  {1'b0, 2'd0, 12'd100},
    {1'b1, 2'd1, 12'd201}, {1'b0, 2'd1, 12'd200},
    {1'b1, 2'd2, 12'd100}, {1'b1, 2'd2, 12'd200}, {1'b1, 2'd2, 12'd150},
    {1'b0, 2'd2, 12'd99},  {1'b0, 2'd2, 12'd201},
    {1'b1, 2'd3, 12'd99},  {1'b1, 2'd3, 12'd201},
    {1'b0, 2'd3, 12'd100}, {1'b0, 2'd3, 12'd200}, {1'b0, 2'd3, 12'd150}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic [11:0] res_data = '0;
  logic [3:0] res_chan = '0;
  logic [1:0] cfg_mode = '0;
  logic [31:0] cfg_window = '0;
  logic [3:0] cfg_chan_sel = '0;
  logic cfg_watch_all = 1'b1;
  logic [1:0] cfg_filter = '0;
  logic stat_rd = 1'b0, ien_set = 1'b0, ien_clr = 1'b0;
  logic evt_flag, ien_mask, irq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_window_watch i_adc_window_watch (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .cfg_mode(cfg_mode), .cfg_window(cfg_window),
    .cfg_chan_sel(cfg_chan_sel), .cfg_watch_all(cfg_watch_all),
    .cfg_filter(cfg_filter), .stat_rd(stat_rd), .ien_set(ien_set),
    .ien_clr(ien_clr), .evt_flag(evt_flag), .ien_mask(ien_mask), .irq(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] ch, input logic [11:0] v);
    @(negedge clk); res_valid = 1'b1; res_chan = ch; res_data = v;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfg_window = {4'h0, 12'd200, 4'h0, 12'd100};
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 flag", evt_flag, 1'b0);
    check("R12 mask", ien_mask, 1'b0);
    check("R12 irq", irq, 1'b0);
    rst_n = 1'b1;

    // R1..R4 table walk; also checks R5 field placement and R8 clear
    for (int i = 0; i < NVEC; i++) begin
      cfg_mode = VEC[i][13:12];
      push(4'd1, VEC[i][11:0]);
      case (VEC[i][13:12])
        2'd0: check("R1 below", evt_flag, VEC[i][14]);
        2'd1: check("R2 above", evt_flag, VEC[i][14]);
        2'd2: check("R3 inside", evt_flag, VEC[i][14]);
        default: check("R4 outside", evt_flag, VEC[i][14]);
      endcase
      rd_pulse();
      check("R8 cleared", evt_flag, 1'b0);
    end

    // R5: bits outside the threshold fields are ignored
    cfg_window = {4'hF, 12'd200, 4'hF, 12'd100};
    cfg_mode = 2'd2;
    push(4'd0, 12'd150);
    check("R5 ignored bits inside", evt_flag, 1'b1);
    rd_pulse();
    push(4'd0, 12'd99);
    check("R5 ignored bits low edge", evt_flag, 1'b0);
    cfg_window = {4'h0, 12'd200, 4'h0, 12'd100};

    // R6: channel select
    cfg_watch_all = 1'b0; cfg_chan_sel = 4'd3; cfg_mode = 2'd0;
    push(4'd2, 12'd5);
    check("R6 other channel", evt_flag, 1'b0);
    push(4'd3, 12'd5);
    check("R6 selected channel", evt_flag, 1'b1);
    rd_pulse();

    // R7: filter 2 -> three consecutive matches
    cfg_filter = 2'd2;
    push(4'd3, 12'd5); push(4'd3, 12'd5);
    check("R7 two matches", evt_flag, 1'b0);
    push(4'd3, 12'd150);              // non-match resets
    push(4'd3, 12'd5); push(4'd3, 12'd5);
    check("R7 reset by miss", evt_flag, 1'b0);
    push(4'd9, 12'd150);              // unwatched channel keeps count (R6)
    push(4'd3, 12'd5);
    check("R7 third match", evt_flag, 1'b1);
    rd_pulse();
    push(4'd3, 12'd5);
    check("R7 count restarts", evt_flag, 1'b0);
    cfg_filter = 2'd0;
    rd_pulse();

    // R9: event and read in same cycle
    @(negedge clk); res_valid = 1'b1; res_chan = 4'd3; res_data = 12'd5; stat_rd = 1'b1;
    @(negedge clk); res_valid = 1'b0; stat_rd = 1'b0;
    check("R9 event wins", evt_flag, 1'b1);

    // R10 / R11: enable and interrupt
    check("R11 masked", irq, 1'b0);
    @(negedge clk); ien_set = 1'b1;
    @(negedge clk); ien_set = 1'b0;
    check("R10 set", ien_mask, 1'b1);
    check("R11 irq on", irq, 1'b1);
    rd_pulse();
    check("R11 irq off when flag clear", irq, 1'b0);
    @(negedge clk); ien_set = 1'b1; ien_clr = 1'b1;
    @(negedge clk); ien_set = 1'b0; ien_clr = 1'b0;
    check("R10 clear wins", ien_mask, 1'b0);
    push(4'd3, 12'd5);
    check("R11 flag without enable", irq, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule